// File: doc/BRIEF.md
# Vector Saturating Narrowing Shifter

This block is one stage of a vector datapath. It takes a 128-bit source vector made of wide lanes and shifts every lane right by an immediate amount. It can round the shifted value. It then clamps the result into an element half as wide. The narrow results are written into either the even or the odd narrow slots of a 128-bit destination. All other slots, and every byte whose predicate bit is clear, keep the value supplied on the old-destination input.

Three saturation flavours are supported: signed in to signed out, unsigned in to unsigned out, and signed in to unsigned out. Every operation reports whether any active lane clamped. A sticky flag accumulates these events until a synchronous clear arrives. The result is registered, so it appears one clock after the valid strobe.

Top module: `vns_shift_narrow`

## Requirements
- R1: `size_i`=0 treats the source as eight 16-bit lanes narrowed to 8 bits. `size_i`=1 treats it as four 32-bit lanes narrowed to 16 bits. Lane i occupies source bits [W*i+W-1 : W*i], where W is the lane width.
- R2: Lane i writes narrow element 2*i when `top_i`=0 and element 2*i+1 when `top_i`=1. Narrow element k occupies `dst_o` bits [N*k+N-1 : N*k], where N is the narrow width. Elements that are not selected take the value of `dst_old_i`.
- R3: `mode_i`=0 (signed) shifts arithmetically and clamps to [-128,127] for byte results or [-32768,32767] for halfword results. `mode_i`=3 behaves exactly as 0.
- R4: `mode_i`=1 (unsigned) shifts logically and clamps to [0,255] or [0,65535].
- R5: `mode_i`=2 (signed to unsigned) reads the source as signed, shifts arithmetically and clamps to [0,255] or [0,65535], so any negative result becomes 0.
- R6: With `round_i`=1, bit (`shamt_i`-1) of the unshifted source is added to the shifted value before clamping. The sum is formed at full precision, so it cannot wrap. `shamt_i` ranges over 1..8 for byte results and 1..16 for halfword results.
- R7: Destination byte b (bits [8b+7:8b]) takes the new value only when `pred_i[b]`=1. Otherwise it takes `dst_old_i` byte b. With `pred_i`=0 the output equals `dst_old_i` and no saturation is reported.
- R8: `sat_o` is 1 in the cycle after an operation in which at least one lane clamped while the predicate bit of the lowest byte of that lane's destination element was 1. Clamping in a lane whose lowest destination byte is predicated off is not reported.
- R9: `sticky_o` becomes 1 whenever `sat_o` becomes 1. It falls only on the clock after `sat_clr_i`=1. When a clear and a new saturation arrive in the same cycle, the flag stays set.
- R10: Results appear one clock after `valid_i`, with `valid_o`=1. In cycles without `valid_i`, `valid_o` and `sat_o` are 0 and `dst_o` holds its last value.
- R11: While `rst_n` is low at a clock edge, `dst_o`, `valid_o`, `sat_o` and `sticky_o` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 1 | 0: 16-to-8 lanes, 1: 32-to-16 lanes |
| top_i | input | 1 | 0: even narrow slots, 1: odd narrow slots |
| mode_i | input | 2 | Saturation flavour (0 signed, 1 unsigned, 2 signed to unsigned, 3 as 0) |
| round_i | input | 1 | Rounding enable |
| shamt_i | input | 5 | Right shift amount, 1-based |
| pred_i | input | 16 | Byte write predicate |
| src_i | input | 128 | Wide source vector |
| dst_old_i | input | 128 | Previous destination contents |
| sat_clr_i | input | 1 | Synchronous clear of the sticky flag |
| dst_o | output | 128 | New destination value |
| valid_o | output | 1 | Result valid |
| sat_o | output | 1 | Saturation in the last operation |
| sticky_o | output | 1 | Accumulated saturation flag |

## Verification
The hardest case to reach is a lane that saturates while its destination is only partly predicated. The flag must follow the lowest byte of that element alone, even when the other byte of the same element is written. The bench reaches it with extreme inputs (most negative, most positive, all ones) at the smallest and largest shifts, combined with alternating and sparse predicate masks. A saturating lane then sits under every predicate combination in both the even and the odd slot selections. Long random runs follow, with the sticky clear pulsed at random. These runs compare against a behavioural model every clock, including cycles where clear and saturation coincide.

// File: rtl/vns_pkg.sv
// Package: shared types for the saturating narrowing shifter.
// Assumes: mode encoding is fixed by the issuing pipeline.
package vns_pkg;
    typedef enum logic [1:0] {
        VNS_SIGNED   = 2'd0,
        VNS_UNSIGNED = 2'd1,
        VNS_S2U      = 2'd2,
        VNS_ALTSIGN  = 2'd3
    } vns_mode_e;
endpackage

// File: rtl/vns_lane.sv
// Module: vns_lane
// One wide lane: shift right, optionally round, clamp into half width.
// Assumes shamt in 1..IN_W/2 (a shamt of 0 disables the rounding bit).
// The work is done two bits wider than the lane so the rounding add and
// the sign of unsigned inputs are both exact.
module vns_lane
    import vns_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int SH_W = 5
) (
    input  logic [IN_W-1:0]   src_i,
    input  vns_mode_e         mode_i,
    input  logic              round_i,
    input  logic [SH_W-1:0]   shamt_i,
    output logic [IN_W/2-1:0] res_o,
    output logic              sat_o
);
    localparam int OUT_W = IN_W / 2;
    localparam int EXT_W = IN_W + 2;
    localparam logic signed [EXT_W-1:0] S_HI = EXT_W'((64'sd1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] S_LO = EXT_W'(-(64'sd1 <<< (OUT_W - 1)));
    localparam logic signed [EXT_W-1:0] U_HI = EXT_W'((64'sd1 <<< OUT_W) - 1);
    localparam logic signed [EXT_W-1:0] U_LO = '0;

    logic signed [EXT_W-1:0] ext, shifted, rtap, sum, hi, lo;
    logic                    rbit;

    // Extend, shift and round at full precision.
    always_comb begin
        ext     = (mode_i == VNS_UNSIGNED) ? {2'b00, src_i}
                                           : {{2{src_i[IN_W-1]}}, src_i};
        shifted = ext >>> shamt_i;
        rtap    = ext >>> (shamt_i - 1'b1);
        rbit    = round_i && (shamt_i != '0) && rtap[0];
        sum     = shifted + {{(EXT_W-1){1'b0}}, rbit};
    end

    // Pick the clamp window for the mode.
    always_comb begin
        if (mode_i == VNS_UNSIGNED || mode_i == VNS_S2U) begin
            hi = U_HI;
            lo = U_LO;
        end else begin
            hi = S_HI;
            lo = S_LO;
        end
    end

    // Clamp and report.
    always_comb begin
        if (sum > hi) begin
            res_o = hi[OUT_W-1:0];
            sat_o = 1'b1;
        end else if (sum < lo) begin
            res_o = lo[OUT_W-1:0];
            sat_o = 1'b1;
        end else begin
            res_o = sum[OUT_W-1:0];
            sat_o = 1'b0;
        end
    end
endmodule

// File: rtl/vns_merge.sv
// Module: vns_merge
// Places narrow results into even or odd slots and merges under the byte
// predicate; also masks lane saturation by each element's lowest byte.
// Assumes VEC_W is a multiple of 32.
module vns_merge #(
    parameter int VEC_W = 128
) (
    input  logic                 size_i,
    input  logic                 top_i,
    input  logic [VEC_W/2-1:0]   rb_i,
    input  logic [VEC_W/16-1:0]  sb_i,
    input  logic [VEC_W/2-1:0]   rh_i,
    input  logic [VEC_W/32-1:0]  sh_i,
    input  logic [VEC_W/8-1:0]   pred_i,
    input  logic [VEC_W-1:0]     old_i,
    output logic [VEC_W-1:0]     new_o,
    output logic                 sat_o
);
    localparam int NB    = VEC_W / 16;
    localparam int NH    = VEC_W / 32;
    localparam int BYTES = VEC_W / 8;

    logic [VEC_W-1:0] placed;

    // Drop each narrow result into its selected slot.
    always_comb begin
        placed = old_i;
        if (!size_i) begin
            for (int j = 0; j < NB; j++)
                placed[16*j + (top_i ? 8 : 0) +: 8] = rb_i[8*j +: 8];
        end else begin
            for (int j = 0; j < NH; j++)
                placed[32*j + (top_i ? 16 : 0) +: 16] = rh_i[16*j +: 16];
        end
    end

    // Byte-wise predicate merge.
    always_comb begin
        for (int b = 0; b < BYTES; b++)
            new_o[8*b +: 8] = pred_i[b] ? placed[8*b +: 8] : old_i[8*b +: 8];
    end

    // Saturation counts only where the element's lowest byte is enabled.
    always_comb begin
        sat_o = 1'b0;
        if (!size_i) begin
            for (int j = 0; j < NB; j++)
                sat_o = sat_o | (sb_i[j] & pred_i[2*j + (top_i ? 1 : 0)]);
        end else begin
            for (int j = 0; j < NH; j++)
                sat_o = sat_o | (sh_i[j] & pred_i[4*j + (top_i ? 2 : 0)]);
        end
    end
endmodule

// File: rtl/vns_shift_narrow.sv
// Module: vns_shift_narrow (top)
// Vector saturating narrowing right shift with top/bottom placement,
// byte predication, per-operation and sticky saturation flags.
// Assumes operands are stable in the cycle valid_i is high; one-cycle latency.
module vns_shift_narrow
    import vns_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SH_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic                 size_i,
    input  logic                 top_i,
    input  logic [1:0]           mode_i,
    input  logic                 round_i,
    input  logic [SH_W-1:0]      shamt_i,
    input  logic [VEC_W/8-1:0]   pred_i,
    input  logic [VEC_W-1:0]     src_i,
    input  logic [VEC_W-1:0]     dst_old_i,
    input  logic                 sat_clr_i,
    output logic [VEC_W-1:0]     dst_o,
    output logic                 valid_o,
    output logic                 sat_o,
    output logic                 sticky_o
);
    localparam int NB = VEC_W / 16;
    localparam int NH = VEC_W / 32;

    vns_mode_e           mode;
    logic [VEC_W/2-1:0]  rb, rh;
    logic [NB-1:0]       sb;
    logic [NH-1:0]       sh;
    logic [VEC_W-1:0]    merged;
    logic                op_sat;

    assign mode = vns_mode_e'(mode_i);

    // Byte-result lanes (16-bit sources).
    for (genvar j = 0; j < NB; j++) begin : g_blane
        vns_lane #(.IN_W(16), .SH_W(SH_W)) u_lane (
            .src_i(src_i[16*j +: 16]), .mode_i(mode), .round_i(round_i),
            .shamt_i(shamt_i), .res_o(rb[8*j +: 8]), .sat_o(sb[j]));
    end

    // Halfword-result lanes (32-bit sources).
    for (genvar j = 0; j < NH; j++) begin : g_hlane
        vns_lane #(.IN_W(32), .SH_W(SH_W)) u_lane (
            .src_i(src_i[32*j +: 32]), .mode_i(mode), .round_i(round_i),
            .shamt_i(shamt_i), .res_o(rh[16*j +: 16]), .sat_o(sh[j]));
    end

    vns_merge #(.VEC_W(VEC_W)) u_merge (
        .size_i(size_i), .top_i(top_i), .rb_i(rb), .sb_i(sb),
        .rh_i(rh), .sh_i(sh), .pred_i(pred_i), .old_i(dst_old_i),
        .new_o(merged), .sat_o(op_sat));

    // Output register and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_o    <= '0;
            valid_o  <= 1'b0;
            sat_o    <= 1'b0;
            sticky_o <= 1'b0;
        end else begin
            valid_o  <= valid_i;
            sat_o    <= valid_i & op_sat;
            sticky_o <= (sticky_o & ~sat_clr_i) | (valid_i & op_sat);
            if (valid_i)
                dst_o <= merged;
        end
    end

    assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sticky_o) |-> $past(sat_clr_i));

    assert_sat_in_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> sticky_o);

    assert_pred_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pred_i == '0) |=> (dst_o == $past(dst_old_i) && !sat_o));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && !sat_o && $stable(dst_o)));
endmodule

// File: tb/vns_shift_narrow_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the DUT every clock.
module vns_shift_narrow_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0, size_i = 1'b0, top_i = 1'b0, round_i = 1'b0;
    logic [1:0]   mode_i = '0;
    logic [4:0]   shamt_i = 5'd1;
    logic [15:0]  pred_i = '0;
    logic [127:0] src_i = '0, dst_old_i = '0;
    logic         sat_clr_i = 1'b0;
    logic [127:0] dst_o;
    logic         valid_o, sat_o, sticky_o;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [127:0] e_dst = '0;
    bit e_valid = 0, e_sat = 0, e_sticky = 0;

    always #4 clk = ~clk;

    vns_shift_narrow dut_i (.*);

    // Reference for one lane.
    function automatic void ref_lane(input longint v, input int inw, input int mode,
                                     input bit rnd, input int sh,
                                     output longint r, output bit s);
        longint x, hi, lo;
        int ow = inw / 2;
        x = v;
        if (mode != 1 && v[inw-1]) x = v - (64'sd1 <<< inw);
        r = x >>> sh;
        if (rnd) r = r + ((x >>> (sh - 1)) & 1);
        if (mode == 1 || mode == 2) begin hi = (64'sd1 <<< ow) - 1; lo = 0; end
        else begin hi = (64'sd1 <<< (ow - 1)) - 1; lo = -(64'sd1 <<< (ow - 1)); end
        s = 0;
        if (r > hi) begin r = hi; s = 1; end
        else if (r < lo) begin r = lo; s = 1; end
    endfunction

    // Reference for a whole operation.
    function automatic void ref_op(output logic [127:0] d, output bit s);
        int inw = size_i ? 32 : 16;
        int ow = inw / 2;
        int nl = 128 / inw;
        d = dst_old_i;
        s = 0;
        for (int i = 0; i < nl; i++) begin
            longint v, r;
            bit ls;
            int e, fb;
            v = 0;
            for (int k = 0; k < inw; k++) v[k] = src_i[inw*i + k];
            ref_lane(v, inw, int'(mode_i), round_i, int'(shamt_i), r, ls);
            e = 2*i + (top_i ? 1 : 0);
            fb = e * ow / 8;
            for (int k = 0; k < ow/8; k++)
                if (pred_i[fb + k]) d[8*(fb+k) +: 8] = r[8*k +: 8];
            if (ls && pred_i[fb]) s = 1;
        end
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Advance the model and DUT by one clock, then compare.
    task automatic cycle(input string tag);
        logic [127:0] d;
        bit s;
        if (!rst_n) begin
            e_dst = '0; e_valid = 0; e_sat = 0; e_sticky = 0;
        end else begin
            s = 0;
            if (valid_i) begin ref_op(d, s); e_dst = d; end
            e_valid  = valid_i;
            e_sat    = valid_i & s;
            e_sticky = (e_sticky & ~sat_clr_i) | (valid_i & s);
        end
        @(negedge clk);
        chk(tag, dst_o, e_dst);
        chk("R10 valid", 128'(valid_o), 128'(e_valid));
        chk("R8 sat", 128'(sat_o), 128'(e_sat));
        chk("R9 sticky", 128'(sticky_o), 128'(e_sticky));
    endtask

    task automatic op(input bit sz, input bit tp, input int md, input bit rnd,
                      input int sh, input logic [15:0] pr, input logic [127:0] src,
                      input logic [127:0] old, input string tag);
        valid_i = 1; size_i = sz; top_i = tp; mode_i = 2'(md); round_i = rnd;
        shamt_i = 5'(sh); pred_i = pr; src_i = src; dst_old_i = old;
        cycle(tag);
        valid_i = 0;
    endtask

    task automatic idle(input string tag);
        valid_i = 0;
        src_i = ~src_i;
        dst_old_i = ~dst_old_i;
        cycle(tag);
    endtask

    localparam logic [127:0] OLD = 128'h5A5A_C3C3_0F0F_9696_A5A5_3C3C_F0F0_6969;
    localparam logic [127:0] EXB = {2{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001}};
    localparam logic [127:0] EXH = {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0180};

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cycle("R11 reset");
        rst_n = 1;
        // R3 signed, extremes, smallest and largest shift
        for (int r = 0; r < 2; r++) begin
            op(0, 0, 0, r[0], 1, 16'hFFFF, EXB, OLD, "R3");
            op(0, 0, 0, r[0], 8, 16'hFFFF, EXB, OLD, "R3");
            op(0, 1, 3, r[0], 8, 16'hFFFF, EXB, OLD, "R3 mode3");
            // R4 unsigned
            op(0, 0, 1, r[0], 1, 16'hFFFF, EXB, OLD, "R4");
            op(0, 1, 1, r[0], 8, 16'hFFFF, EXB, OLD, "R4");
            // R5 signed to unsigned
            op(0, 0, 2, r[0], 1, 16'hFFFF, EXB, OLD, "R5");
            op(0, 1, 2, r[0], 8, 16'hFFFF, EXB, OLD, "R5");
            // R1 halfword lanes
            op(1, 0, 0, r[0], 1, 16'hFFFF, EXH, OLD, "R1");
            op(1, 1, 1, r[0], 16, 16'hFFFF, EXH, OLD, "R1");
            op(1, 0, 2, r[0], 16, 16'hFFFF, EXH, OLD, "R1");
        end
        // R6 rounding carries across, no wrap at max unsigned
        op(0, 0, 1, 1, 1, 16'hFFFF, {8{16'h01FF}}, OLD, "R6");
        op(1, 0, 1, 1, 16, 16'hFFFF, {4{32'hFFFF_FFFF}}, OLD, "R6");
        op(0, 0, 0, 1, 8, 16'hFFFF, {8{16'h7F80}}, OLD, "R6");
        // R2 placement top vs bottom with no saturation
        op(0, 0, 1, 0, 4, 16'hFFFF, {8{16'h0120}}, OLD, "R2");
        op(0, 1, 1, 0, 4, 16'hFFFF, {8{16'h0120}}, OLD, "R2");
        op(1, 1, 0, 0, 2, 16'hFFFF, {4{32'h0000_1234}}, OLD, "R2");
        // R7 predicate masks
        op(0, 0, 0, 0, 1, 16'hA5A5, EXB, OLD, "R7");
        op(0, 1, 0, 0, 1, 16'h0000, EXB, OLD, "R7 none");
        // R8 saturation hidden when element low byte is off
        op(0, 0, 0, 0, 1, 16'hAAAA, {8{16'h7FFF}}, OLD, "R8");
        op(1, 1, 0, 0, 1, 16'h7777, {4{32'h7FFF_FFFF}}, OLD, "R8");
        op(1, 1, 0, 0, 1, 16'h4444, {4{32'h7FFF_FFFF}}, OLD, "R8");
        // R9 clear, and clear together with new saturation
        sat_clr_i = 1; idle("R9"); sat_clr_i = 0;
        op(0, 0, 0, 0, 1, 16'hFFFF, EXB, OLD, "R9");
        sat_clr_i = 1;
        op(0, 0, 0, 0, 1, 16'hFFFF, EXB, OLD, "R9 both");
        sat_clr_i = 0;
        // R10 idle hold
        idle("R10"); idle("R10");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            bit sz = 1'($urandom);
            int sh = sz ? 1 + int'($urandom % 16) : 1 + int'($urandom % 8);
            sat_clr_i = ($urandom % 8) == 0;
            if (($urandom % 5) == 0) idle("R10 rnd");
            else op(sz, 1'($urandom), int'($urandom % 4), 1'($urandom), sh,
                    16'($urandom), {$urandom, $urandom, $urandom, $urandom},
                    {$urandom, $urandom, $urandom, $urandom}, "R1 rnd");
        end
        sat_clr_i = 0;
        // R11 reset again mid-run
        rst_n = 0; cycle("R11 reset"); rst_n = 1;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule